// File: doc/BRIEF.md
# Time-Referenced Periodic Pulse Generator

This block produces a square wave on a single output pin that is locked to the nanoseconds field of a free-running time counter. Software stages three values through a small write port: how long the pin stays high, how long it stays low (together these make the period), and the start phase. It then sets enable or stop in a pending control word and commits with a sync write. Once the generator is armed, it waits for the time counter's nanoseconds value to reach the start phase. It then drives the pin high and alternates between the two levels for the programmed durations.

The time counter is outside the block. Each cycle the block receives the live nanoseconds value and the number of nanoseconds that elapsed in that cycle. After the first edge, durations are measured as elapsed time rather than by absolute compares, so when the nanoseconds field wraps at the end of a second the waveform is not disturbed. A clear control resets the generator at once. New durations and phase only take hold through a sync while the generator is idle, so a running waveform is reprogrammed by clearing or stopping first.

Top module: `tpg_pulse_gen`

## Requirements
- R1: After reset the pin is low, and it stays low until a sync commits an enable.
- R2: A staged high or low duration is rounded up to the next multiple of 16 ns. A value of zero stays zero.
- R3: A staged start phase is rounded up to a multiple of 16, and any result below 16 is replaced by 16.
- R4: Staging durations, phase or the enable bit has no effect on the pin until a write to select 4 with data bit 0 set (sync).
- R5: A sync whose pending control has enable (bit 0 of a select-3 write) set and stop clear arms an idle generator. The pin goes high in the cycle after the first cycle in which the nanoseconds input is at least the start phase.
- R6: After the pin goes high, each level lasts until the elapsed nanoseconds (the sum of the per-cycle step input) reach the programmed duration. The pin then toggles, and any overshoot is carried into the next level.
- R7: A sync with stop (bit 1 of the select-3 write) pending drives the pin low in the next cycle and returns the generator to idle. Stop takes priority over enable.
- R8: A select-3 write with bit 2 (clear) set drives the pin low in the next cycle and idles the generator without a sync. It also discards pending enable and stop.
- R9: A sync while the generator is busy (armed or running) changes neither the committed durations and phase nor the waveform.
- R10: If the committed high duration is zero the pin stays low after arming. If only the low duration is zero the pin stays high after the start phase is reached.
- R11: A wrap of the nanoseconds input while the waveform runs leaves every period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ns_now | input | 32 | Live nanoseconds value of the time counter |
| tick_ns | input | 4 | Nanoseconds elapsed in this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 high time, 1 low time, 2 start phase, 3 control, 4 sync |
| wr_data | input | 32 | Write data |
| pulse_o | output | 1 | Generated pin level |

## Verification
Every result appears one clock after the edge that causes it. Clear and stop lower the pin one cycle after their write. Arming happens at the sync edge, and the rise comes one cycle after the first matching nanoseconds value. Each toggle comes one cycle after the edge at which the accumulated step reaches the remaining duration. A behavioural model in the bench steps on the same edge as the design, and its pin level is compared at every falling edge. Directed checks count whole cycles between rising edges and after stop and clear writes, so each check samples exactly where the one-cycle latency puts the result.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_HOLD  = 3'd4
  } gen_state_e;

  localparam logic [2:0] SEL_HIGH  = 3'd0;
  localparam logic [2:0] SEL_LOW   = 3'd1;
  localparam logic [2:0] SEL_PHASE = 3'd2;
  localparam logic [2:0] SEL_CTRL  = 3'd3;
  localparam logic [2:0] SEL_SYNC  = 3'd4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_STOP_BIT = 1;
  localparam int CTRL_CLR_BIT  = 2;
  localparam int SYNC_BIT      = 0;
endpackage

// File: rtl/tpg_cfg_regs.sv
module tpg_cfg_regs
  import tpg_pkg::*;
#(
  parameter int TW        = 32,
  parameter int GRAN      = 16,
  parameter int MIN_PHASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  input  logic          gen_busy,
  output logic [TW-1:0] act_high,
  output logic [TW-1:0] act_low,
  output logic [TW-1:0] act_phase,
  output logic          start_o,
  output logic          stop_o,
  output logic          clear_o
);
  localparam int GL = $clog2(GRAN);
  localparam logic [TW-1:0] PHASE_FLOOR = TW'(MIN_PHASE);

  function automatic logic [TW-1:0] round_up(input logic [TW-1:0] v);
    logic [TW:0] s;
    s = {1'b0, v} + (TW+1)'(GRAN - 1);
    return TW'((s >> GL) << GL);
  endfunction

  logic [TW-1:0] stg_high_q, stg_high_d;
  logic [TW-1:0] stg_low_q, stg_low_d;
  logic [TW-1:0] stg_phase_q, stg_phase_d;
  logic [TW-1:0] act_high_q, act_low_q, act_phase_q;
  logic          pend_en_q, pend_en_d, pend_stop_q, pend_stop_d;
  logic          stg_en, act_en, pend_wr;
  logic          sync_hit, ctrl_hit;
  logic [TW-1:0] phase_rnd;

  assign sync_hit = wr_en && (wr_sel == SEL_SYNC) && wr_data[SYNC_BIT];
  assign ctrl_hit = wr_en && (wr_sel == SEL_CTRL);
  assign clear_o  = ctrl_hit && wr_data[CTRL_CLR_BIT];
  assign stop_o   = sync_hit && pend_stop_q;
  assign start_o  = sync_hit && pend_en_q && !pend_stop_q && !gen_busy;
  assign act_en   = sync_hit && !gen_busy;
  assign phase_rnd = round_up(wr_data);

  always_comb begin
    stg_high_d  = stg_high_q;
    stg_low_d   = stg_low_q;
    stg_phase_d = stg_phase_q;
    stg_en      = 1'b0;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_HIGH:  begin stg_high_d = round_up(wr_data); stg_en = 1'b1; end
        SEL_LOW:   begin stg_low_d = round_up(wr_data); stg_en = 1'b1; end
        SEL_PHASE: begin
          stg_phase_d = (phase_rnd < PHASE_FLOOR) ? PHASE_FLOOR : phase_rnd;
          stg_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    pend_en_d   = pend_en_q;
    pend_stop_d = pend_stop_q;
    pend_wr     = 1'b0;
    if (ctrl_hit) begin
      pend_wr = 1'b1;
      if (wr_data[CTRL_CLR_BIT]) begin
        pend_en_d   = 1'b0;
        pend_stop_d = 1'b0;
      end else begin
        pend_en_d   = wr_data[CTRL_EN_BIT];
        pend_stop_d = wr_data[CTRL_STOP_BIT];
      end
    end else if (sync_hit) begin
      pend_wr     = 1'b1;
      pend_en_d   = 1'b0;
      pend_stop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_high_q  <= '0;
      stg_low_q   <= '0;
      stg_phase_q <= PHASE_FLOOR;
    end else if (stg_en) begin
      stg_high_q  <= stg_high_d;
      stg_low_q   <= stg_low_d;
      stg_phase_q <= stg_phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en_q   <= 1'b0;
      pend_stop_q <= 1'b0;
    end else if (pend_wr) begin
      pend_en_q   <= pend_en_d;
      pend_stop_q <= pend_stop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_high_q  <= '0;
      act_low_q   <= '0;
      act_phase_q <= PHASE_FLOOR;
    end else if (act_en) begin
      act_high_q  <= stg_high_q;
      act_low_q   <= stg_low_q;
      act_phase_q <= stg_phase_q;
    end
  end

  assign act_high  = act_high_q;
  assign act_low   = act_low_q;
  assign act_phase = act_phase_q;

  // R9
  busy_sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && gen_busy) |=> ($stable(act_high_q) && $stable(act_low_q) && $stable(act_phase_q)));

  // R3
  phase_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_phase_q >= PHASE_FLOOR);
endmodule

// File: rtl/tpg_wave_seq.sv
module tpg_wave_seq
  import tpg_pkg::*;
#(
  parameter int TW     = 32,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     ns_now,
  input  logic [STEP_W-1:0] tick_ns,
  input  logic [TW-1:0]     act_high,
  input  logic [TW-1:0]     act_low,
  input  logic [TW-1:0]     act_phase,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              clear_i,
  output logic              pin_o,
  output logic              busy_o
);
  gen_state_e    st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          pin_q, pin_d;
  logic          cnt_en;
  logic [TW-1:0] tick_ext, over;
  logic          expire, phase_hit;

  assign tick_ext  = {{(TW-STEP_W){1'b0}}, tick_ns};
  assign expire    = tick_ext >= cnt_q;
  assign over      = tick_ext - cnt_q;
  assign phase_hit = ns_now >= act_phase;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pin_d  = pin_q;
    cnt_en = 1'b0;
    if (clear_i || stop_i) begin
      st_d   = ST_IDLE;
      pin_d  = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (start_i) begin
      st_d  = ST_ARMED;
      pin_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ARMED: begin
          if (phase_hit) begin
            if (act_high == '0) begin
              st_d  = ST_HOLD;
              pin_d = 1'b0;
            end else if (act_low == '0) begin
              st_d  = ST_HOLD;
              pin_d = 1'b1;
            end else begin
              st_d   = ST_HIGH;
              pin_d  = 1'b1;
              cnt_d  = act_high;
              cnt_en = 1'b1;
            end
          end
        end
        ST_HIGH: begin
          cnt_en = 1'b1;
          if (expire) begin
            st_d  = ST_LOW;
            pin_d = 1'b0;
            cnt_d = act_low - over;
          end else begin
            cnt_d = cnt_q - tick_ext;
          end
        end
        ST_LOW: begin
          cnt_en = 1'b1;
          if (expire) begin
            st_d  = ST_HIGH;
            pin_d = 1'b1;
            cnt_d = act_high - over;
          end else begin
            cnt_d = cnt_q - tick_ext;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pin_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pin_q <= pin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pin_o  = pin_q;
  assign busy_o = (st_q != ST_IDLE);

  // R7
  stop_clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i || clear_i) |=> (!pin_q && st_q == ST_IDLE));

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !pin_q);

  // R5
  arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && phase_hit && act_high != '0 && !stop_i && !clear_i) |=> pin_q);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !stop_i && !clear_i) |=> $stable(pin_q));

  // R6
  high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HIGH) |-> pin_q);
endmodule

// File: rtl/tpg_pulse_gen.sv
module tpg_pulse_gen
  import tpg_pkg::*;
#(
  parameter int TW        = 32,
  parameter int STEP_W    = 4,
  parameter int GRAN      = 16,
  parameter int MIN_PHASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     ns_now,
  input  logic [STEP_W-1:0] tick_ns,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [TW-1:0]     wr_data,
  output logic              pulse_o
);
  logic [TW-1:0] act_high, act_low, act_phase;
  logic          start_p, stop_p, clear_p, busy;

  tpg_cfg_regs #(
    .TW(TW), .GRAN(GRAN), .MIN_PHASE(MIN_PHASE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .gen_busy(busy),
    .act_high(act_high), .act_low(act_low), .act_phase(act_phase),
    .start_o(start_p), .stop_o(stop_p), .clear_o(clear_p)
  );

  tpg_wave_seq #(
    .TW(TW), .STEP_W(STEP_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ns_now(ns_now), .tick_ns(tick_ns),
    .act_high(act_high), .act_low(act_low), .act_phase(act_phase),
    .start_i(start_p), .stop_i(stop_p), .clear_i(clear_p),
    .pin_o(pulse_o), .busy_o(busy)
  );
endmodule

// File: tb/test_tpg_pulse_gen.sv
module test_tpg_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NS_WRAP    = 1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ns_now;
  logic [3:0]  tick_ns;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        pulse_o;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_state; // 0 idle 1 armed 2 high 3 low 4 hold
  longint m_cnt, sh, sl, sp, ah, al, ap;
  bit m_pin, pe, ps;

  tpg_pulse_gen i_tpg_pulse_gen (
    .clk(clk), .rst_n(rst_n), .ns_now(ns_now), .tick_ns(tick_ns),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pulse_o(pulse_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ns_now <= 32'd0;
    else if (ns_now + tick_ns >= NS_WRAP) ns_now <= ns_now + tick_ns - NS_WRAP;
    else ns_now <= ns_now + tick_ns;
  end

  function automatic longint rup(longint v);
    return ((v + 15) / 16) * 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_pin = 0; pe = 0; ps = 0;
      sh = 0; sl = 0; sp = 16; ah = 0; al = 0; ap = 16;
    end else begin
      bit busy, clr, stp, sta, load;
      longint t;
      busy = (m_state != 0); clr = 0; stp = 0; sta = 0; load = 0;
      t = tick_ns;
      if (wr_en) begin
        case (wr_sel)
          3'd0: sh = rup(wr_data);
          3'd1: sl = rup(wr_data);
          3'd2: begin sp = rup(wr_data); if (sp < 16) sp = 16; end
          3'd3: if (wr_data[2]) begin clr = 1; pe = 0; ps = 0; end
                else begin pe = wr_data[0]; ps = wr_data[1]; end
          3'd4: if (wr_data[0]) begin
                  stp = ps; sta = pe && !ps && !busy; load = !busy;
                  pe = 0; ps = 0;
                end
          default: ;
        endcase
      end
      if (clr || stp) begin
        m_state = 0; m_pin = 0; m_cnt = 0;
      end else if (sta) begin
        m_state = 1; m_pin = 0;
      end else if (m_state == 1) begin
        if (ns_now >= ap) begin
          if (ah == 0) begin m_state = 4; m_pin = 0; end
          else if (al == 0) begin m_state = 4; m_pin = 1; end
          else begin m_state = 2; m_pin = 1; m_cnt = ah; end
        end
      end else if (m_state == 2 || m_state == 3) begin
        if (t >= m_cnt) begin
          m_cnt = ((m_state == 2) ? al : ah) - (t - m_cnt);
          m_pin = (m_state == 3);
          m_state = (m_state == 2) ? 3 : 2;
        end else m_cnt = m_cnt - t;
      end
      if (load) begin ah = sh; al = sl; ap = sp; end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pulse_o !== m_pin) begin
        failures++;
        $display("FAIL %s model compare at %0t: actual=%b expected=%b", cur_req, $time, pulse_o, m_pin);
      end
    end
  end

  task automatic expect_pin(input bit exp, input string req);
    checks++;
    if (pulse_o !== exp) begin
      failures++;
      $display("FAIL %s pin: actual=%b expected=%b", req, pulse_o, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles between two rising edges of the pin
  task automatic check_period(input int exp, input string req);
    int n;
    bit prev;
    prev = pulse_o;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (pulse_o && !prev) break;
      prev = pulse_o;
    end
    n = 0;
    prev = pulse_o;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (pulse_o && !prev) break;
      prev = pulse_o;
    end
    checks++;
    if (n != exp) begin
      failures++;
      $display("FAIL %s period cycles: actual=%0d expected=%0d", req, n, exp);
    end
  endtask

  // cycles the pin stays high after a rise
  task automatic check_high_width(input int exp, input string req);
    int n;
    bit prev;
    prev = pulse_o;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (pulse_o && !prev) break;
      prev = pulse_o;
    end
    n = 0;
    for (int i = 0; i < 400; i++) begin
      if (!pulse_o) break;
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != exp) begin
      failures++;
      $display("FAIL %s high cycles: actual=%0d expected=%0d", req, n, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 32'd0; tick_ns = 4'd8;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    expect_pin(1'b0, "R1");
    idle(10);
    expect_pin(1'b0, "R1");

    // R4: staged but not committed
    cur_req = "R4";
    wr(3'd0, 32'd30);
    wr(3'd1, 32'd40);
    wr(3'd2, 32'd100);
    wr(3'd3, 32'd1);
    for (int i = 0; i < 5; i++) begin idle(4); expect_pin(1'b0, "R4"); end

    // R2 R5 R6: 30 -> 32 ns high (4 cycles), 40 -> 48 ns low, period 10 cycles
    cur_req = "R2 R5 R6";
    wr(3'd4, 32'd1);
    check_high_width(4, "R2");
    check_period(10, "R6");

    // R9: busy sync with new durations has no effect
    cur_req = "R9";
    wr(3'd0, 32'd64);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    check_high_width(4, "R9");
    check_period(10, "R9");

    // R11: several wraps of the nanoseconds field (wrap every 125 cycles)
    cur_req = "R11";
    for (int k = 0; k < 30; k++) check_period(10, "R11");

    // R7: stop wins over enable
    cur_req = "R7";
    wr(3'd3, 32'd3);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'd1;
    @(negedge clk); wr_en = 1'b0;
    expect_pin(1'b0, "R7");
    for (int i = 0; i < 5; i++) begin idle(6); expect_pin(1'b0, "R7"); end

    // R3: phase 5 becomes 16; tick 4, 16 ns high and low
    cur_req = "R3";
    tick_ns = 4'd4;
    wr(3'd0, 32'd16);
    wr(3'd1, 32'd16);
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    check_period(8, "R3");
    idle(300);

    // R8: clear without sync
    cur_req = "R8";
    check_high_width(4, "R8");
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'd4;
    @(negedge clk); wr_en = 1'b0;
    expect_pin(1'b0, "R8");
    for (int i = 0; i < 5; i++) begin idle(5); expect_pin(1'b0, "R8"); end

    // R10: zero high stays low, zero low stays high
    cur_req = "R10";
    tick_ns = 4'd8;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd32);
    wr(3'd2, 32'd200);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    for (int i = 0; i < 10; i++) begin idle(30); expect_pin(1'b0, "R10"); end
    wr(3'd3, 32'd4);
    wr(3'd0, 32'd32);
    wr(3'd1, 32'd0);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    idle(200);
    for (int i = 0; i < 10; i++) begin idle(20); expect_pin(1'b1, "R10"); end

    // R6: overshoot carried with an odd step (48 + 32 ns at 5 ns per cycle)
    cur_req = "R6";
    wr(3'd3, 32'd4);
    tick_ns = 4'd5;
    wr(3'd0, 32'd48);
    wr(3'd1, 32'd32);
    wr(3'd2, 32'd16);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    idle(600);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule